// File: doc/BRIEF.md
# Unconditional Branch Next-PC Unit

This block owns the program counter and the link register of a simple in-order fetch/execute model. Each cycle it may receive one 32-bit instruction word together with a valid strobe. When the word carries the unconditional displacement-branch opcode, the block computes the next instruction address. That address is either the current address plus a scaled, sign-extended displacement, or the displacement alone when the word asks for an absolute target. When the word asks for linking, the block also saves the return address. Any other valid word moves the counter forward by one instruction.

A side port lets surrounding logic read the link register and overwrite it, in the way a move-to/move-from instruction would. For every executed branch the block also reports a one-cycle taken pulse and the target address, so that the fetch stage can redirect.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_out` loads `RESET_VEC` (default 0x100), `lr_out` loads 0, `taken` loads 0 and `target_out` loads 0.
- R2: A valid word is a branch exactly when bits 31:26 equal 18 (0x48000000 with the other fields zero). All four combinations of the two flag bits transfer control. Every other opcode is treated as a non-branch.
- R3: The displacement is bits 25:2, read as a signed word count. It is multiplied by 4 and sign-extended to 64 bits, giving byte offsets from -2^25 to 2^25-4. Every target is therefore 4-byte aligned.
- R4: When bit 1 of the word is 0, the new `pc_out` is the old `pc_out` plus the displacement, wrapping modulo 2^64.
- R5: When bit 1 of the word is 1, the new `pc_out` is the sign-extended displacement itself.
- R6: When bit 0 of the word is 1, `lr_out` becomes the old `pc_out` + 4, in both the relative and the absolute mode. When bit 0 is 0, the branch leaves `lr_out` unchanged.
- R7: A valid non-branch word advances `pc_out` by 4, wrapping modulo 2^64, and leaves `taken` low.
- R8: With `instr_valid` low, `pc_out` holds, `taken` is low, and `lr_out` changes only through the side port.
- R9: When `lr_wr_en` is high, `lr_out` shows `lr_wr_data` after the next edge. `lr_out` always shows the current link register.
- R10: If a side-port write arrives in the same cycle as a valid linking branch, the branch's return address wins.
- R11: After a valid branch, `taken` is high for exactly one cycle, and in that same cycle `target_out` and `pc_out` both equal the branch target.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| lr_wr_en | input | 1 | Side-port write strobe for the link register |
| lr_wr_data | input | ADDR_W | Side-port write data |
| pc_out | output | ADDR_W | Current program counter |
| lr_out | output | ADDR_W | Current link register |
| taken | output | 1 | One-cycle pulse after an executed branch |
| target_out | output | ADDR_W | Target of the most recent executed branch |

## Verification
The hardest case to reach is wraparound of the 64-bit counter, because reset places the counter near zero. The bench first takes an absolute branch with the most negative displacement, which puts the counter at 0xFFFFFFFFFE000000. A relative branch with the largest positive displacement then brings it to the last word below 2^64, and a non-branch word wraps it to zero. After that, a relative branch backwards from zero wraps it the other way. The bench also sweeps every opcode value and all four flag combinations against a set of boundary displacements, and it forces the collision between a side-port write and a linking branch.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  localparam int INSN_W   = 32;
  localparam int OPC_W    = 6;
  localparam int LI_W     = 24;
  localparam int OPC_LSB  = INSN_W - OPC_W;
  localparam int LI_LSB   = 2;
  localparam int ABS_BIT  = 1;
  localparam int LINK_BIT = 0;
  localparam logic [OPC_W-1:0] BR_OPC = 6'd18;

  typedef struct packed {
    logic            is_branch;
    logic            absolute;
    logic            link;
    logic [LI_W-1:0] li;
  } br_dec_t;
endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
  import bnpc_pkg::*;
(
  input  logic              valid,
  input  logic [INSN_W-1:0] word,
  output br_dec_t           dec
);
  always_comb begin
    dec.is_branch = valid && (word[INSN_W-1:OPC_LSB] == BR_OPC);
    dec.absolute  = word[ABS_BIT];
    dec.link      = word[LINK_BIT];
    dec.li        = word[LI_LSB +: LI_W];
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  br_dec_t           dec,
  output logic [ADDR_W-1:0] branch_tgt,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam int EXT_W = ADDR_W - LI_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_W / 8);

  logic [ADDR_W-1:0] disp;

  always_comb begin
    disp       = {{EXT_W{dec.li[LI_W-1]}}, dec.li, 2'b00};
    seq_pc     = cur_pc + STEP;
    branch_tgt = dec.absolute ? disp : (cur_pc + disp);
  end
endmodule

// File: rtl/bnpc_lr.sv
module bnpc_lr #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] lr_q
);
  always_ff @(posedge clk) begin
    if (rst)          lr_q <= '0;
    else if (link_en) lr_q <= link_addr;
    else if (wr_en)   lr_q <= wr_data;
  end

  // R10
  link_wins_chk: assert property (@(posedge clk) disable iff (rst)
    link_en |=> lr_q == $past(link_addr));

  // R9
  side_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !link_en) |=> lr_q == $past(wr_data));

  // R8
  lr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !link_en) |=> $stable(lr_q));
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int                ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] RESET_VEC = 64'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic              lr_wr_en,
  input  logic [ADDR_W-1:0] lr_wr_data,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] lr_out,
  output logic              taken,
  output logic [ADDR_W-1:0] target_out
);
  br_dec_t           dec;
  logic [ADDR_W-1:0] branch_tgt;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              taken_q;

  bnpc_decode u_dec (
    .valid (instr_valid),
    .word  (instr_word),
    .dec   (dec)
  );

  bnpc_target #(.ADDR_W(ADDR_W)) u_tgt (
    .cur_pc     (pc_q),
    .dec        (dec),
    .branch_tgt (branch_tgt),
    .seq_pc     (seq_pc)
  );

  bnpc_lr #(.ADDR_W(ADDR_W)) u_lr (
    .clk       (clk),
    .rst       (rst),
    .link_en   (dec.is_branch && dec.link),
    .link_addr (seq_pc),
    .wr_en     (lr_wr_en),
    .wr_data   (lr_wr_data),
    .lr_q      (lr_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_VEC;
      tgt_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= dec.is_branch;
      if (dec.is_branch) begin
        pc_q  <= branch_tgt;
        tgt_q <= branch_tgt;
      end else if (instr_valid) begin
        pc_q  <= seq_pc;
      end
    end
  end

  assign pc_out     = pc_q;
  assign target_out = tgt_q;
  assign taken      = taken_q;

  // R11
  taken_target_chk: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> pc_q == tgt_q);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(pc_q) && !taken_q));

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_word[31:26] != 6'd18) |=>
      (pc_q == $past(pc_q) + ADDR_W'(4) && !taken_q));

  // R3
  aligned_chk: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> tgt_q[1:0] == 2'b00);
endmodule

// File: tb/bnpc_unit_tb.sv
`timescale 1ns/1ps
module bnpc_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic        lr_wr_en;
  logic [63:0] lr_wr_data;
  logic [63:0] pc_out, lr_out, target_out;
  logic        taken;

  int checks = 0;
  int fails  = 0;
  logic [63:0] e_pc, e_lr;

  always #2 clk = ~clk;

  bnpc_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .lr_wr_en(lr_wr_en), .lr_wr_data(lr_wr_data), .pc_out(pc_out),
    .lr_out(lr_out), .taken(taken), .target_out(target_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic we,
                      input logic [63:0] wd, input string req);
    logic        br, lk;
    logic [63:0] disp, tgt;
    br   = v && (w[31:26] == 6'd18);
    lk   = br && w[0];
    disp = 64'(longint'(signed'(w[25:2])) * 4);
    tgt  = w[1] ? disp : e_pc + disp;
    if (lk)      e_lr = e_pc + 64'd4;
    else if (we) e_lr = wd;
    if (br)      e_pc = tgt;
    else if (v)  e_pc = e_pc + 64'd4;
    instr_valid = v; instr_word = w; lr_wr_en = we; lr_wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0; lr_wr_en = 1'b0;
    chk({req, " pc"}, pc_out, e_pc);
    chk({req, " lr"}, lr_out, e_lr);
    chk({req, " taken"}, {63'd0, taken}, {63'd0, br});
    if (br) chk({req, " R11 target"}, target_out, tgt);
  endtask

  function automatic logic [31:0] br_word(input logic [23:0] li, input logic a, input logic l);
    return {6'd18, li, a, l};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] lis [7];
    lis = '{24'h000000, 24'h000001, 24'h7FFFFF, 24'h800000,
            24'hFFFFFF, 24'h123456, 24'hABCDEF};
    rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
    lr_wr_en = 1'b0; lr_wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_pc = 64'h100; e_lr = 64'd0;
    // R1 reset state
    chk("R1 pc", pc_out, 64'h100);
    chk("R1 lr", lr_out, 64'd0);
    chk("R1 taken", {63'd0, taken}, 64'd0);
    chk("R1 target", target_out, 64'd0);

    // R2 R3 R4 R5 R6 sweep of flag combinations and boundary displacements
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 7; i++)
        step(1'b1, br_word(lis[i], f[1], f[0]), 1'b0, '0, "R2/R4/R5/R6 sweep");

    // R2 R7 every other opcode advances sequentially
    for (int op = 0; op < 64; op++)
      if (op != 18)
        step(1'b1, {6'(op), 26'h2AAAAAB}, 1'b0, '0, "R7 non-branch");

    // R8 idle holds
    step(1'b0, br_word(24'h000010, 1'b0, 1'b1), 1'b0, '0, "R8 idle");
    step(1'b0, 32'h0, 1'b0, '0, "R8 idle");

    // R9 side-port write
    step(1'b0, 32'h0, 1'b1, 64'hDEAD_BEEF_0000_1234, "R9 side write");
    step(1'b1, 32'h7C00_0000, 1'b1, 64'h0123_4567_89AB_CDEF, "R9 side write");
    // side write plus non-linking branch: write stands
    step(1'b1, br_word(24'h000004, 1'b0, 1'b0), 1'b1, 64'h5555, "R9 side write");

    // R10 collision: linking branch wins
    step(1'b1, br_word(24'h000008, 1'b0, 1'b1), 1'b1, 64'hBAD0_BAD0, "R10 collision");
    step(1'b1, br_word(24'hFFFFF0, 1'b1, 1'b1), 1'b1, 64'hBAD1_BAD1, "R10 collision");

    // R4 R7 wraparound of the 64-bit counter
    step(1'b1, br_word(24'h800000, 1'b1, 1'b0), 1'b0, '0, "R5 abs min");
    chk("R5 abs min pc", pc_out, 64'hFFFF_FFFF_FE00_0000);
    step(1'b1, br_word(24'h7FFFFF, 1'b0, 1'b0), 1'b0, '0, "R4 rel max");
    chk("R4 top pc", pc_out, 64'hFFFF_FFFF_FFFF_FFFC);
    step(1'b1, 32'h0, 1'b0, '0, "R7 wrap");
    chk("R7 wrap pc", pc_out, 64'd0);
    step(1'b1, br_word(24'hFFFFFF, 1'b0, 1'b1), 1'b0, '0, "R4 back wrap");
    chk("R4 back wrap pc", pc_out, 64'hFFFF_FFFF_FFFF_FFFC);
    chk("R6 lr link at zero", lr_out, 64'd4);

    // R11 pulse lasts one cycle
    step(1'b1, br_word(24'h000040, 1'b1, 1'b0), 1'b0, '0, "R11 pulse");
    step(1'b0, 32'h0, 1'b0, '0, "R11 pulse drop");

    // R1 reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    e_pc = 64'h100; e_lr = 64'd0;
    chk("R1 re-reset pc", pc_out, 64'h100);
    chk("R1 re-reset lr", lr_out, 64'd0);
    chk("R1 re-reset taken", {63'd0, taken}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule